// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the raw D+ and D- wires of a low-speed USB link, oversampled by a system clock that is not an integer multiple of the bit rate. It hunts for the sync field and locks onto its closing pair of K bits. It then turns the line into bytes and writes them into a small on-chip buffer.

A fractional bit timer places one sample near the centre of every bit. The receiver NRZI-decodes each sample, drops stuffed bits, and assembles bytes least significant bit first. Each stored byte is announced with a one-cycle strobe.

A single-ended zero at a data sample ends the packet. When the line then returns to idle, the block produces a done pulse and the count of stored bytes. It also flags a packet that ran past the buffer, and it pulses a sync error when a start-of-packet attempt never reaches its double K. The controlling logic reads the stored bytes through a registered read port. PID, CRC and endpoint checks belong to later logic.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is high and in the cycle after it, byte_stb, byte_data, byte_cnt, pkt_done, overflow and sync_err are all zero.
- R2: Line codes are {dp,dm} = 01 for J (idle), 10 for K and 00 for SE0. A packet is accepted only after a J-to-K edge followed, one bit later, by a second K sample. A K that is followed by J is rejected, and the hunt for the next J-to-K edge resumes. Any number of K-J pairs, including none, may come before the closing double K.
- R3: After a rejected candidate, if no J-to-K edge arrives within HUNT_LIMIT cycles (default 24), sync_err pulses for exactly one cycle. No byte is stored and no done pulse follows.
- R4: Bit samples follow a fractional timer of CLK_NUM/CLK_DEN cycles per bit (default 32/3). Consecutive samples are 10 or 11 cycles apart, three bits take 32 cycles, and three bytes take 256 cycles. A packet of 11 bytes at exactly this rate is received without error.
- R5: A sample equal to the previous one decodes as 1, and a change decodes as 0. The last sync bit is the first reference. Decoded bits fill each byte from bit 0 upward.
- R6: After six decoded ones in a row, the next bit is dropped and does not enter the byte. The final sync bit counts as the first of these ones.
- R7: Each stored byte gives one single-cycle byte_stb with the byte on byte_data. The n-th byte of a packet is written to buffer address n. rd_data shows the word at rd_addr one cycle after the address is applied.
- R8: An SE0 at any data sample ends the packet. The bits of an incomplete byte are discarded.
- R9: When the line shows J after the SE0, pkt_done pulses for one cycle, exactly 3 cycles after J is applied at the pins. At that moment byte_cnt is loaded with the number of stored bytes.
- R10: Bytes beyond BUF_DEPTH (default 8) are neither stored nor strobed. overflow then goes high and stays high until the next packet locks, and byte_cnt never exceeds BUF_DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dp | input | 1 | D+ line, asynchronous |
| dm | input | 1 | D- line, asynchronous |
| rd_addr | input | $clog2(BUF_DEPTH) | Buffer read address |
| rd_data | output | 8 | Buffer word at rd_addr, one cycle later |
| byte_stb | output | 1 | One-cycle pulse per stored byte |
| byte_data | output | 8 | Byte accompanying byte_stb |
| byte_cnt | output | $clog2(BUF_DEPTH+1) | Stored bytes of the last finished packet |
| pkt_done | output | 1 | One-cycle pulse when a packet has finished |
| overflow | output | 1 | Last packet exceeded the buffer |
| sync_err | output | 1 | One-cycle pulse when the sync hunt times out |

## Verification
The line inputs pass two synchronizer flops before any decision is taken. This makes pkt_done due exactly three cycles after the bench drives J, and that latency is checked at the exact falling edge where it should appear.

Byte results have no fixed cycle relative to the bench's symbol boundaries, because the sample points drift inside each bit with the 11/11/10 pattern. A monitor therefore logs every byte_stb at falling edges, and the log is compared in order with the encoded bytes after the packet's done pulse. Buffer contents are read back one cycle after each address is set.

The sync timeout has no fixed cycle either, so it is judged after a quiet window well beyond the hunt limit. At that point exactly one sync_err pulse must have been seen, with no bytes and no done pulse.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  // Line state, encoded as {dp, dm}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } lstate_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_CONFIRM,
    RX_HUNT,
    RX_DATA,
    RX_EOP
  } rxst_t;
endpackage

// File: rtl/usbrx_line_in.sv
module usbrx_line_in
  import usbrx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    dp_i,
  input  logic    dm_i,
  output lstate_t ls_o,
  output lstate_t ls_prev_o
);
  logic [1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= LS_J;
          else     pipe[0] <= {dp_i, dm_i};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= LS_J;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign ls_o = lstate_t'(pipe[STAGES-1]);

  always_ff @(posedge clk) begin
    if (rst) ls_prev_o <= LS_J;
    else     ls_prev_o <= ls_o;
  end
endmodule

// File: rtl/usbrx_bit_timer.sv
// Fractional bit timer: the credit counts in units of 1/DEN cycle.
module usbrx_bit_timer #(
  parameter int CLK_NUM = 32,
  parameter int CLK_DEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic tick_o
);
  // After a restart the first tick falls 1.5 bit times later.
  localparam int LOAD = CLK_NUM + CLK_NUM / 2;
  localparam int W    = $clog2(LOAD + 1) + 1;
  localparam logic [W-1:0] K_LOAD = W'(LOAD);
  localparam logic [W-1:0] K_NUM  = W'(CLK_NUM);
  localparam logic [W-1:0] K_DEN  = W'(CLK_DEN);
  localparam logic [W-1:0] K_STEP = W'(CLK_NUM - CLK_DEN);

  logic [W-1:0] credit;
  logic         due;

  assign due    = (credit <= K_DEN);
  assign tick_o = due && !restart_i;

  always_ff @(posedge clk) begin
    if (rst)            credit <= K_NUM;
    else if (restart_i) credit <= K_LOAD;
    else if (due)       credit <= credit + K_STEP;
    else                credit <= credit - K_DEN;
  end
endmodule

// File: rtl/usbrx_deser.sv
// NRZI decode, stuffed-bit removal and LSB-first byte assembly.
module usbrx_deser #(
  parameter int RUN = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       shift_i,
  input  logic       lvl_k_i,
  output logic       vld_o,
  output logic [7:0] byte_o
);
  localparam int OW = $clog2(RUN + 1);
  localparam logic [OW-1:0] K_RUN = OW'(RUN);

  logic          prev_k;
  logic [OW-1:0] ones;
  logic [2:0]    nbit;
  logic [7:0]    sr;
  logic          bit_v;
  logic [7:0]    sr_nx;
  logic          stuffed;

  assign bit_v   = (lvl_k_i == prev_k);
  assign sr_nx   = {bit_v, sr[7:1]};
  assign stuffed = (ones == K_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_k <= 1'b1;
      ones   <= '0;
      nbit   <= '0;
      sr     <= '0;
      vld_o  <= 1'b0;
      byte_o <= '0;
    end else begin
      vld_o <= 1'b0;
      if (start_i) begin
        prev_k <= 1'b1;            // last sync bit was K
        ones   <= OW'(1);          // and decoded as a one
        nbit   <= '0;
      end else if (shift_i) begin
        prev_k <= lvl_k_i;
        if (stuffed) begin
          ones <= '0;
        end else begin
          sr   <= sr_nx;
          ones <= bit_v ? ones + OW'(1) : '0;
          nbit <= nbit + 3'd1;
          if (nbit == 3'd7) begin
            vld_o  <= 1'b1;
            byte_o <= sr_nx;
          end
        end
      end
    end
  end
endmodule

// File: rtl/usbrx_buf.sv
module usbrx_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [7:0]    wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [7:0]    rd_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
    rd_o <= mem[ra_i];
  end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usbrx_pkg::*;
#(
  parameter int CLK_NUM     = 32,
  parameter int CLK_DEN     = 3,
  parameter int BUF_DEPTH   = 8,
  parameter int HUNT_LIMIT  = 24,
  parameter int SYNC_STAGES = 2,
  parameter int STUFF_RUN   = 6,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dp,
  input  logic          dm,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          byte_stb,
  output logic [7:0]    byte_data,
  output logic [CW-1:0] byte_cnt,
  output logic          pkt_done,
  output logic          overflow,
  output logic          sync_err
);
  localparam int HW = $clog2(HUNT_LIMIT + 1);
  localparam logic [HW-1:0] K_HUNT_END = HW'(HUNT_LIMIT - 1);
  localparam logic [CW-1:0] K_DEPTH    = CW'(BUF_DEPTH);

  lstate_t       ls, ls_prev;
  rxst_t         st;
  logic          jk_edge;
  logic          bit_tick, tmr_restart;
  logic          lock, shift_en;
  logic          byte_vld;
  logic [7:0]    byte_v;
  logic [CW-1:0] wcnt;
  logic          room, wr_en;
  logic [HW-1:0] hunt_cnt;

  usbrx_line_in #(.STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst(rst), .dp_i(dp), .dm_i(dm),
    .ls_o(ls), .ls_prev_o(ls_prev)
  );

  assign jk_edge     = (ls_prev == LS_J) && (ls == LS_K);
  assign tmr_restart = jk_edge && ((st == RX_IDLE) || (st == RX_HUNT));

  usbrx_bit_timer #(.CLK_NUM(CLK_NUM), .CLK_DEN(CLK_DEN)) u_tmr (
    .clk(clk), .rst(rst), .restart_i(tmr_restart), .tick_o(bit_tick)
  );

  assign lock     = (st == RX_CONFIRM) && bit_tick && (ls == LS_K);
  assign shift_en = (st == RX_DATA) && bit_tick && (ls != LS_SE0);

  usbrx_deser #(.RUN(STUFF_RUN)) u_deser (
    .clk(clk), .rst(rst), .start_i(lock), .shift_i(shift_en),
    .lvl_k_i(ls == LS_K), .vld_o(byte_vld), .byte_o(byte_v)
  );

  assign room  = (wcnt < K_DEPTH);
  assign wr_en = byte_vld && room;

  usbrx_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we_i(wr_en), .wa_i(wcnt[AW-1:0]), .wd_i(byte_v),
    .ra_i(rd_addr), .rd_o(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      hunt_cnt  <= '0;
      wcnt      <= '0;
      byte_stb  <= 1'b0;
      byte_data <= '0;
      byte_cnt  <= '0;
      pkt_done  <= 1'b0;
      overflow  <= 1'b0;
      sync_err  <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      pkt_done <= 1'b0;
      sync_err <= 1'b0;

      case (st)
        RX_IDLE: if (jk_edge) st <= RX_CONFIRM;
        RX_CONFIRM: begin
          if (bit_tick) begin
            if (ls == LS_K) begin
              st <= RX_DATA;
            end else begin
              st       <= RX_HUNT;
              hunt_cnt <= '0;
            end
          end
        end
        RX_HUNT: begin
          if (jk_edge) begin
            st <= RX_CONFIRM;
          end else if (hunt_cnt == K_HUNT_END) begin
            sync_err <= 1'b1;
            st       <= RX_IDLE;
          end else begin
            hunt_cnt <= hunt_cnt + HW'(1);
          end
        end
        RX_DATA: if (bit_tick && (ls == LS_SE0)) st <= RX_EOP;
        RX_EOP: begin
          if (ls == LS_J) begin
            pkt_done <= 1'b1;
            byte_cnt <= wcnt;
            st       <= RX_IDLE;
          end
        end
        default: st <= RX_IDLE;
      endcase

      if (lock) begin
        wcnt     <= '0;
        overflow <= 1'b0;
      end else if (byte_vld) begin
        if (room) begin
          wcnt      <= wcnt + CW'(1);
          byte_stb  <= 1'b1;
          byte_data <= byte_v;
        end else begin
          overflow <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/usbrx_checker.sv
module usbrx_checker #(
  parameter int CLK_NUM   = 32,
  parameter int CLK_DEN   = 3,
  parameter int BUF_DEPTH = 8,
  parameter int CW        = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          byte_stb,
  input logic          pkt_done,
  input logic          overflow,
  input logic          sync_err,
  input logic          bit_tick,
  input logic          tmr_restart,
  input logic [CW-1:0] byte_cnt
);
  localparam int GAP_LO = CLK_NUM / CLK_DEN;
  localparam int GAP_HI = (CLK_NUM + CLK_DEN - 1) / CLK_DEN;

  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tmr_restart) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (bit_tick) begin
      gap  <= 8'd1;
      seen <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap <= gap + 8'd1;
    end
  end

  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && seen) |-> ((int'(gap) >= GAP_LO) && (int'(gap) <= GAP_HI)));

  assert_sync_err_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    sync_err |=> !sync_err);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done);

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> !byte_stb);

  assert_no_store_after_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    overflow |-> !byte_stb);

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    int'(byte_cnt) <= BUF_DEPTH);
endmodule

bind usb_ls_rx usbrx_checker #(
  .CLK_NUM(CLK_NUM), .CLK_DEN(CLK_DEN), .BUF_DEPTH(BUF_DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .byte_stb(byte_stb), .pkt_done(pkt_done),
  .overflow(overflow), .sync_err(sync_err), .bit_tick(bit_tick),
  .tmr_restart(tmr_restart), .byte_cnt(byte_cnt)
);

// File: tb/sim_usb_ls_rx.sv
module sim_usb_ls_rx;
  localparam int NUM   = 32;
  localparam int DEN   = 3;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [1:0] SYM_J = 2'b01, SYM_K = 2'b10, SYM_SE0 = 2'b00;

  // {length, b3, b2, b1, b0}; b0 is sent first
  localparam logic [39:0] VEC [6] = '{
    {8'd1, 32'h000000A5},
    {8'd2, 32'h0000813F},
    {8'd3, 32'h00FFFF7E},
    {8'd4, 32'h12345678},
    {8'd4, 32'h00FF00FF},
    {8'd2, 32'h0000C3E0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dp  = 1'b0;
  logic          dm  = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data, byte_data;
  logic          byte_stb, pkt_done, overflow, sync_err;
  logic [CW-1:0] byte_cnt;

  usb_ls_rx u0 (
    .clk(clk), .rst(rst), .dp(dp), .dm(dm), .rd_addr(rd_addr), .rd_data(rd_data),
    .byte_stb(byte_stb), .byte_data(byte_data), .byte_cnt(byte_cnt),
    .pkt_done(pkt_done), .overflow(overflow), .sync_err(sync_err)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit reported = 0;
  logic [7:0] txb [16];
  logic [1:0] sym [256];
  int nsym;
  logic enc_k;
  int enc_ones;
  logic [7:0] cap [512];
  int ncap = 0, ndone = 0, nserr = 0;
  int done_cnt = 0;
  logic done_ovf = 1'b0;

  // Port monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (byte_stb) begin
        if (ncap < 512) cap[ncap] = byte_data;
        ncap++;
      end
      if (pkt_done) begin
        ndone++;
        done_cnt = int'(byte_cnt);
        done_ovf = overflow;
      end
      if (sync_err) nserr++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  endtask

  task automatic push_sym(input logic [1:0] s);
    sym[nsym] = s;
    nsym++;
  endtask

  task automatic push_bit(input logic b);
    if (b) enc_ones++;
    else begin enc_k = !enc_k; enc_ones = 0; end
    push_sym(enc_k ? SYM_K : SYM_J);
    if (enc_ones == 6) begin
      enc_k = !enc_k;
      enc_ones = 0;
      push_sym(enc_k ? SYM_K : SYM_J);
    end
  endtask

  // Sync (npairs K-J pairs then K K), data bytes, extra bits, SE0 x2
  task automatic build(input int npairs, input int nbytes, input int nextra, input logic [7:0] xv);
    nsym = 0;
    for (int p = 0; p < npairs; p++) begin push_sym(SYM_K); push_sym(SYM_J); end
    push_sym(SYM_K); push_sym(SYM_K);
    enc_k = 1'b1;
    enc_ones = 1;
    for (int i = 0; i < nbytes; i++)
      for (int b = 0; b < 8; b++) push_bit(txb[i][b]);
    for (int b = 0; b < nextra; b++) push_bit(xv[b]);
    push_sym(SYM_SE0); push_sym(SYM_SE0);
  endtask

  // Symbol i lasts floor(NUM*(i+1)/DEN) - floor(NUM*i/DEN) cycles
  task automatic play();
    for (int i = 0; i < nsym; i++) begin
      {dp, dm} = sym[i];
      repeat ((NUM * (i + 1)) / DEN - (NUM * i) / DEN) @(negedge clk);
    end
  endtask

  task automatic run_pkt(input int exp_cnt, input logic exp_ovf);
    int base_cap, base_done, lat;
    base_cap  = ncap;
    base_done = ndone;
    play();
    {dp, dm} = SYM_J;
    lat = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (pkt_done && lat == 0) lat = k;
    end
    repeat (30) @(negedge clk);
    chk(lat == 3, "R9 done latency", lat, 3);
    chk(ndone == base_done + 1, "R9 done pulses", ndone - base_done, 1);
    chk(done_cnt == exp_cnt, "R9 byte_cnt", done_cnt, exp_cnt);
    chk(done_ovf == exp_ovf, "R10 overflow flag", int'(done_ovf), int'(exp_ovf));
    chk(ncap - base_cap == exp_cnt, "R7 strobe count", ncap - base_cap, exp_cnt);
    for (int i = 0; i < exp_cnt; i++)
      chk(cap[base_cap + i] == txb[i], "R5 R6 strobed byte", int'(cap[base_cap + i]), int'(txb[i]));
    for (int i = 0; i < exp_cnt; i++) begin
      rd_addr = AW'(i);
      @(negedge clk);
      chk(rd_data == txb[i], "R7 buffer word", int'(rd_data), int'(txb[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: during and right after reset
    chk(byte_stb == 0 && pkt_done == 0 && sync_err == 0, "R1 pulses in reset",
        int'({byte_stb, pkt_done, sync_err}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(byte_cnt == 0, "R1 byte_cnt", int'(byte_cnt), 0);
    chk(overflow == 0, "R1 overflow", int'(overflow), 0);
    chk(byte_data == 0, "R1 byte_data", int'(byte_data), 0);
    chk(byte_stb == 0 && pkt_done == 0 && sync_err == 0, "R1 pulses after reset",
        int'({byte_stb, pkt_done, sync_err}), 0);
    repeat (20) @(negedge clk);

    // Table walk: R5 R6 R7 R9 with the standard sync
    for (int v = 0; v < 6; v++) begin
      for (int i = 0; i < 4; i++) txb[i] = VEC[v][8*i +: 8];
      build(3, int'(VEC[v][39:32]), 0, 8'h00);
      run_pkt(int'(VEC[v][39:32]), 1'b0);
    end

    // R2: shortened sync with one K-J pair, and with the bare double K
    txb[0] = 8'h5A; txb[1] = 8'hC3;
    build(1, 2, 0, 8'h00);
    run_pkt(2, 1'b0);
    txb[0] = 8'h3C;
    build(0, 1, 0, 8'h00);
    run_pkt(1, 1'b0);

    // R6: long runs of ones, stuffed bits spanning byte borders
    for (int i = 0; i < 5; i++) txb[i] = 8'hFF;
    build(3, 5, 0, 8'h00);
    run_pkt(5, 1'b0);

    // R8: SE0 mid-byte drops the partial bits; SE0 right after sync
    txb[0] = 8'h96;
    build(3, 1, 3, 8'h05);
    run_pkt(1, 1'b0);
    build(3, 0, 0, 8'h00);
    run_pkt(0, 1'b0);

    // R10 boundary: exactly BUF_DEPTH bytes
    for (int i = 0; i < DEPTH; i++) txb[i] = 8'(i * 29 + 7);
    build(3, DEPTH, 0, 8'h00);
    run_pkt(DEPTH, 1'b0);

    // R4 + R10: 11 bytes at the fractional rate, only 8 kept
    for (int i = 0; i < 11; i++) txb[i] = 8'(i * 17 + 3);
    build(3, 11, 0, 8'h00);
    run_pkt(DEPTH, 1'b1);

    // R10: overflow cleared by the next packet
    txb[0] = 8'h44;
    build(3, 1, 0, 8'h00);
    run_pkt(1, 1'b0);

    // R3 / R2: lone K then idle, the candidate is dropped and the hunt times out
    begin
      int s0, d0, c0;
      s0 = nserr; d0 = ndone; c0 = ncap;
      nsym = 0;
      push_sym(SYM_K); push_sym(SYM_J);
      play();
      repeat (80) @(negedge clk);
      chk(nserr == s0 + 1, "R3 sync_err pulses", nserr - s0, 1);
      chk(ndone == d0, "R3 no done", ndone - d0, 0);
      chk(ncap == c0, "R3 no bytes", ncap - c0, 0);
    end

    // R3: receiver recovers after a timeout
    txb[0] = 8'hE7; txb[1] = 8'h18;
    build(3, 2, 0, 8'h00);
    run_pkt(2, 1'b0);

    summary();
  end
endmodule